// File: doc/BRIEF.md
# I2C master transfer sequencer

This block carries out one master-side I2C transfer at the bit level. A start request, given together with the master and enable controls, makes it put a START condition on the bus. It then sends the target address in either the 7-bit or the 10-bit form. After that it moves as many data bytes as the byte count asks for, in whichever direction the transmit/receive control selects. At the end it issues a STOP if one was requested with the start. If not, it keeps SCL low so that the next request produces a repeated START.

Bus timing comes from an external strobe, `tick`. Each strobe moves the sequencer by one quarter of a bit period: SCL is released for the two middle quarters and pulled low for the first and last. Transmit bytes are taken from a FIFO head and acknowledged with a pop strobe. Received bytes are handed over with a push strobe. Single-cycle pulses report the end of the access, a missing acknowledge and a lost arbitration. A bus-busy flag follows the START and STOP conditions seen on the wired lines.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset, SCL and SDA are both released, and `busy_o`, `stt_o`, `ardy_o`, `nack_o` and `al_o` are all 0.
- R2: A START is SDA falling while SCL is high, and it comes before the first address bit. `stt_o` reads 1 from the cycle after an accepted request until that START has been driven, and 0 after that.
- R3: Inside a transfer, SDA changes only while SCL is low. The only SDA edges while SCL is high are the START and STOP conditions.
- R4: A 7-bit transfer sends one address byte, {sa[6:0], rw}, where rw = 0 for transmit (`trx`=1) and rw = 1 for receive. The byte goes MSB first, and each byte is followed by a ninth acknowledge bit, where low means ACK.
- R5: With `xa`=1, a write sends {11110, sa[9:8], 0} and then sa[7:0]. A read sends those two bytes, then a repeated START, then {11110, sa[9:8], 1}, and only then the data.
- R6: In transmit mode, `cnt` bytes are taken from `tx_data`, one `tx_pop` per byte. Each byte is sent MSB first and the slave's acknowledge bit is sampled after it.
- R7: In receive mode, `cnt` bytes are clocked in MSB first, and each one appears on `rx_data` with a one-cycle `rx_push`. The master ACKs every byte except the last, which it NACKs.
- R8: If `stp_req` was 1 when the start was requested, a STOP follows the last byte and both lines are released. Otherwise SCL stays low, and the next start request produces a repeated START with no STOP in between.
- R9: If the slave does not acknowledge an address byte or a transmitted data byte, `nack_o` and `ardy_o` each pulse once. No further byte is moved, and a STOP follows if one was requested.
- R10: `ardy_o` pulses for exactly one cycle, once per completed or NACK-ended transfer.
- R11: `busy_o` becomes 1 after a START is seen on the bus lines and returns to 0 after a STOP is seen.
- R12: If the bus reads low during a transmitted bit that the block left released, `al_o` pulses once, both lines are released at once, and `ardy_o` does not pulse.
- R13: With `en` low, the block drops any transfer in progress, releases both lines and clears `stt_o`. A start request made while `en` or `mst` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Block enable; low aborts and idles |
| mst | input | 1 | Master mode select; a start request is accepted only when it is high |
| trx | input | 1 | 1 = transmit to slave, 0 = receive from slave |
| xa | input | 1 | 1 = 10-bit address, 0 = 7-bit |
| stt_req | input | 1 | One-cycle start request |
| stp_req | input | 1 | Captured with `stt_req`: end the transfer with STOP |
| sa | input | 10 | Slave address |
| cnt | input | CNT_W | Number of data bytes, 1 or more |
| tick | input | 1 | Quarter-bit timing strobe |
| tx_data | input | 8 | Head of the transmit FIFO |
| tx_pop | output | 1 | Head byte consumed |
| rx_data | output | 8 | Received byte |
| rx_push | output | 1 | `rx_data` valid for one cycle |
| scl_in | input | 1 | SCL bus level |
| sda_in | input | 1 | SDA bus level |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |
| stt_o | output | 1 | Start bit readback |
| busy_o | output | 1 | Bus busy |
| ardy_o | output | 1 | Access-ready pulse |
| nack_o | output | 1 | No-acknowledge pulse |
| al_o | output | 1 | Arbitration-lost pulse |

## Verification
The assertions take for granted that `scl_in` and `sda_in` are the wired-AND of this block's own drive and the other devices' drive. They also take for granted that no other master holds SCL low, and that `trx`, `xa`, `sa` and `cnt` stay constant from the start request until the access ends. The bench builds the bus as that wired-AND. Its slave model changes SDA only after an SCL falling edge. It changes the configuration only between transfers, and it issues a start request only while the block is idle or holding the bus. The arbitration-lost case is produced by having the slave model pull SDA low during the first address bit.

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mst,
  input  logic             trx,
  input  logic             xa,
  input  logic             stt_req,
  input  logic             stp_req,
  input  logic [9:0]       sa,
  input  logic [CNT_W-1:0] cnt,
  input  logic             tick,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  output logic [7:0]       rx_data,
  output logic             rx_push,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             stt_o,
  output logic             busy_o,
  output logic             ardy_o,
  output logic             nack_o,
  output logic             al_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_ADDR, S_AACK, S_DATA, S_DACK, S_STOP, S_HOLD} st_t;
  st_t st;
  logic [1:0] q, astep;
  logic [2:0] bitn;
  logic [7:0] sh;
  logic [CNT_W-1:0] rem;
  logic stp_bit, samp, scl_p, sda_p;

  wire end_bit = tick && q == 2'd3;
  wire smp     = tick && q == 2'd2;
  wire bitst   = st == S_ADDR || st == S_AACK || st == S_DATA || st == S_DACK;
  wire txbit   = st == S_ADDR || (st == S_DATA && trx);
  wire last    = rem == ONE;
  wire st_t    fin_st = stp_bit ? S_STOP : S_HOLD;

  function automatic logic [7:0] addr_byte(input logic [1:0] s);
    case (s)
      2'd0:    addr_byte = xa ? {5'b11110, sa[9:8], 1'b0} : {sa[6:0], ~trx};
      2'd1:    addr_byte = sa[7:0];
      default: addr_byte = {5'b11110, sa[9:8], 1'b1};
    endcase
  endfunction

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START: begin scl_oe = q == 2'd3; sda_oe = q[1]; end
      S_ADDR:  begin scl_oe = q == 2'd0 || q == 2'd3; sda_oe = ~sh[7]; end
      S_DATA:  begin scl_oe = q == 2'd0 || q == 2'd3; sda_oe = trx & ~sh[7]; end
      S_AACK:  scl_oe = q == 2'd0 || q == 2'd3;
      S_DACK:  begin scl_oe = q == 2'd0 || q == 2'd3; sda_oe = ~trx & ~last; end
      S_STOP:  begin scl_oe = q == 2'd0; sda_oe = ~q[1]; end
      S_HOLD:  scl_oe = 1'b1;
      default: ;
    endcase
  end

  assign rx_data = sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; q <= '0; astep <= '0; bitn <= '0; sh <= '0; rem <= '0;
      stt_o <= 1'b0; stp_bit <= 1'b0; samp <= 1'b0;
      tx_pop <= 1'b0; rx_push <= 1'b0; ardy_o <= 1'b0; nack_o <= 1'b0; al_o <= 1'b0;
    end else begin
      tx_pop <= 1'b0; rx_push <= 1'b0; ardy_o <= 1'b0; nack_o <= 1'b0; al_o <= 1'b0;
      if (!en) begin
        st <= S_IDLE; q <= '0; stt_o <= 1'b0; stp_bit <= 1'b0;
      end else begin
        if (stt_req && mst) begin stt_o <= 1'b1; stp_bit <= stp_req; end
        if (st == S_IDLE || st == S_HOLD) begin
          if (tick && stt_o) begin st <= S_START; q <= '0; astep <= '0; rem <= cnt; end
        end else if (tick) q <= q + 2'd1;
        if (st == S_START && tick && q == 2'd1) stt_o <= 1'b0;
        if (smp && bitst) begin
          samp <= sda_in;
          if (st == S_DATA && !trx) sh <= {sh[6:0], sda_in};
          if (txbit && sh[7] && !sda_in) begin
            al_o <= 1'b1; st <= S_IDLE; q <= '0; stt_o <= 1'b0; stp_bit <= 1'b0;
          end
        end
        if (end_bit) begin
          case (st)
            S_START: begin st <= S_ADDR; sh <= addr_byte(astep); bitn <= '0; end
            S_ADDR:
              if (bitn == 3'd7) st <= S_AACK;
              else begin bitn <= bitn + 3'd1; sh <= {sh[6:0], 1'b0}; end
            S_AACK:
              if (samp) begin nack_o <= 1'b1; ardy_o <= 1'b1; st <= fin_st; end
              else if (xa && astep == 2'd0) begin astep <= 2'd1; st <= S_ADDR; sh <= sa[7:0]; bitn <= '0; end
              else if (xa && astep == 2'd1 && !trx) begin astep <= 2'd2; st <= S_START; end
              else begin
                st <= S_DATA; bitn <= '0;
                if (trx) begin sh <= tx_data; tx_pop <= 1'b1; end
              end
            S_DATA:
              if (bitn == 3'd7) begin st <= S_DACK; rx_push <= ~trx; end
              else begin bitn <= bitn + 3'd1; if (trx) sh <= {sh[6:0], 1'b0}; end
            S_DACK:
              if (trx && samp) begin nack_o <= 1'b1; ardy_o <= 1'b1; st <= fin_st; end
              else if (last) begin ardy_o <= 1'b1; st <= fin_st; end
              else begin
                rem <= rem - ONE; st <= S_DATA; bitn <= '0;
                if (trx) begin sh <= tx_data; tx_pop <= 1'b1; end
              end
            S_STOP: begin st <= S_IDLE; stp_bit <= 1'b0; end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= 1'b1; sda_p <= 1'b1; busy_o <= 1'b0;
    end else begin
      scl_p <= scl_in; sda_p <= sda_in;
      if (scl_p && scl_in && sda_p && !sda_in) busy_o <= 1'b1;
      else if (scl_p && scl_in && !sda_p && sda_in) busy_o <= 1'b0;
    end
  end

  a_r3_sda_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bitst && $past(bitst) && !scl_oe && $past(!scl_oe)) |-> sda_oe == $past(sda_oe));
  a_r2_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $fell(stt_o)) |-> (sda_oe && !scl_oe));
  a_r11_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $fell(stt_o)) |=> busy_o);
  a_r12_al_release: assert property (@(posedge clk) disable iff (!rst_n)
    al_o |-> (!ardy_o && !nack_o && !scl_oe && !sda_oe));
  a_r10_ardy_single: assert property (@(posedge clk) disable iff (!rst_n)
    ardy_o |=> !ardy_o);
  a_r6_pop_dir: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> trx);
  a_r7_push_dir: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !trx);
endmodule

// File: tb/i2c_xfer_seq_tb_top.sv
module i2c_xfer_seq_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, en, mst, trx, xa, stt_req, stp_req;
  logic [9:0] sa;
  logic [7:0] cnt;
  logic [1:0] tdiv = 2'd0;
  logic tick;
  logic [7:0] tx_data, rx_data;
  logic tx_pop, rx_push, scl_oe, sda_oe, stt_o, busy_o, ardy_o, nack_o, al_o;
  logic slv_lo = 1'b0;
  logic scl_bus, sda_bus;

  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick = tdiv == 2'd3;
  assign scl_bus = !scl_oe;
  assign sda_bus = !sda_oe && !slv_lo;

  logic [7:0] txq [0:15];
  logic [7:0] sdat [0:15];
  logic [7:0] rxq [0:15];
  int txrd = 0, pops = 0, rxn = 0;
  int ardy_cnt = 0, nack_cnt = 0, al_cnt = 0;
  assign tx_data = txq[txrd[3:0]];

  i2c_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .mst(mst), .trx(trx), .xa(xa),
    .stt_req(stt_req), .stp_req(stp_req), .sa(sa), .cnt(cnt), .tick(tick),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_data(rx_data), .rx_push(rx_push),
    .scl_in(scl_bus), .sda_in(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .stt_o(stt_o), .busy_o(busy_o), .ardy_o(ardy_o), .nack_o(nack_o), .al_o(al_o));

  always @(posedge clk) begin
    if (tx_pop) begin txrd++; pops++; end
    if (rx_push) begin rxq[rxn[3:0]] = rx_data; rxn++; end
    if (ardy_o) ardy_cnt++;
    if (nack_o) nack_cnt++;
    if (al_o) al_cnt++;
  end

  // bus monitor and slave model
  logic [10:0] evlog [0:63];
  logic [10:0] exlog [0:63];
  int evn = 0, exn = 0, bitcnt = 0, gidx = 0;
  int rd_first = 1, ndata = 0, nack_idx = 99;
  bit rd_mode = 0, al_en = 0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] cur = 8'd0;

  task automatic logev(input logic [1:0] t, input logic [7:0] b, input logic a);
    if (evn < 64) evlog[evn] = {t, b, a};
    evn++;
  endtask

  always @(posedge clk) begin
    if (scl_m && scl_bus && sda_m && !sda_bus) begin logev(2'd1, 8'd0, 1'b0); bitcnt = 0; end
    else if (scl_m && scl_bus && !sda_m && sda_bus) logev(2'd2, 8'd0, 1'b0);
    else if (!scl_m && scl_bus) begin
      if (bitcnt < 8) begin cur = {cur[6:0], sda_bus}; bitcnt++; end
      else begin logev(2'd0, cur, sda_bus); bitcnt = 0; gidx++; end
    end else if (scl_m && !scl_bus) begin
      if (al_en && gidx == 0 && bitcnt == 0) slv_lo <= 1'b1;
      else if (bitcnt == 8) slv_lo <= (!rd_mode || gidx < rd_first) && (gidx != nack_idx);
      else if (rd_mode && gidx >= rd_first && gidx < rd_first + ndata)
        slv_lo <= !sdat[(gidx - rd_first) % 16][7 - bitcnt];
      else slv_lo <= 1'b0;
    end
    scl_m = scl_bus;
    sda_m = sda_bus;
  end

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ex(input logic [1:0] t, input logic [7:0] b, input logic a);
    exlog[exn] = {t, b, a};
    exn++;
  endtask

  int exp_pops, exp_nack;

  task automatic build_expect(input bit x, input bit t, input logic [9:0] a, input int n, input bit s, input int nk);
    int g;
    bit dead;
    g = 0; dead = 0; exn = 0; exp_pops = 0; exp_nack = 0;
    ex(2'd1, 8'd0, 1'b0);
    ex(2'd0, x ? {5'b11110, a[9:8], 1'b0} : {a[6:0], ~t}, g == nk);
    if (g == nk) dead = 1;
    g++;
    if (x && !dead) begin
      ex(2'd0, a[7:0], g == nk);
      if (g == nk) dead = 1;
      g++;
      if (!t && !dead) begin
        ex(2'd1, 8'd0, 1'b0);
        ex(2'd0, {5'b11110, a[9:8], 1'b1}, g == nk);
        if (g == nk) dead = 1;
        g++;
      end
    end
    for (int i = 0; i < n && !dead; i++) begin
      if (t) begin
        ex(2'd0, txq[i], g == nk);
        exp_pops++;
        if (g == nk) dead = 1;
      end else ex(2'd0, sdat[i], i == n - 1);
      g++;
    end
    if (dead) exp_nack = 1;
    if (s) ex(2'd2, 8'd0, 1'b0);
  endtask

  task automatic run_xfer(input bit x, input bit t, input logic [9:0] a, input int n, input bit s, input int nk);
    int a0, n0;
    string lab;
    for (int i = 0; i < 16; i++) begin txq[i] = 8'($urandom); sdat[i] = 8'($urandom); end
    rd_mode = !t; rd_first = !x ? 1 : 3; ndata = n; nack_idx = nk;
    @(negedge clk);
    evn = 0; gidx = 0; txrd = 0; pops = 0; rxn = 0;
    a0 = ardy_cnt; n0 = nack_cnt;
    xa = x; trx = t; sa = a; cnt = 8'(n); stt_req = 1'b1; stp_req = s;
    @(negedge clk);
    stt_req = 1'b0; stp_req = 1'b0;
    chk(stt_o == 1'b1, "R2 start bit set", int'(stt_o), 1);
    while (ardy_cnt == a0) @(negedge clk);
    repeat (48) @(negedge clk);
    build_expect(x, t, a, n, s, nk);
    lab = x ? "R5" : "R4";
    chk(evn == exn, {lab, " bus event count"}, evn, exn);
    for (int i = 0; i < exn && i < evn; i++)
      chk(evlog[i] == exlog[i], {lab, " bus event"}, int'(evlog[i]), int'(exlog[i]));
    chk(ardy_cnt - a0 == 1, "R10 ardy pulses", ardy_cnt - a0, 1);
    chk(nack_cnt - n0 == exp_nack, "R9 nack pulses", nack_cnt - n0, exp_nack);
    chk(pops == exp_pops, "R6 tx pops", pops, exp_pops);
    if (!t && exp_nack == 0) begin
      chk(rxn == n, "R7 rx count", rxn, n);
      for (int i = 0; i < n && i < rxn; i++)
        chk(rxq[i] == sdat[i], "R7 rx byte", int'(rxq[i]), int'(sdat[i]));
    end
    chk(stt_o == 1'b0, "R2 start bit cleared", int'(stt_o), 0);
    chk(busy_o == !s, "R11 busy", int'(busy_o), int'(!s));
    chk(scl_oe == !s, "R8 scl hold", int'(scl_oe), int'(!s));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk + 1, nfail);
    $finish;
  end

  initial begin
    int dummy;
    int a0;
    dummy = $urandom(32'h5eed);
    rst_n = 1'b0; en = 1'b1; mst = 1'b1; trx = 1'b1; xa = 1'b0;
    stt_req = 1'b0; stp_req = 1'b0; sa = '0; cnt = 8'd1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R1 lines released", int'({scl_oe, sda_oe}), 0);
    chk(!busy_o && !stt_o, "R1 busy and start", int'({busy_o, stt_o}), 0);
    chk(!ardy_o && !nack_o && !al_o, "R1 events", int'({ardy_o, nack_o, al_o}), 0);

    run_xfer(0, 1, 10'h05A, 3, 1, 99);
    run_xfer(0, 0, 10'h033, 3, 1, 99);
    run_xfer(1, 1, 10'h2C5, 2, 1, 99);
    run_xfer(1, 0, 10'h1A7, 2, 1, 99);
    run_xfer(0, 1, 10'h044, 2, 1, 0);
    run_xfer(0, 1, 10'h011, 3, 1, 2);
    run_xfer(0, 1, 10'h02B, 1, 0, 99);
    run_xfer(0, 0, 10'h02B, 2, 1, 99);
    chk(evlog[0][10:9] == 2'd1, "R8 repeated start first", int'(evlog[0][10:9]), 1);

    for (int k = 0; k < 10; k++)
      run_xfer(1'($urandom), 1'($urandom), 10'($urandom), 1 + int'($urandom % 4), 1, 99);

    // R13: request ignored when not master
    @(negedge clk);
    evn = 0; mst = 1'b0; stt_req = 1'b1;
    @(negedge clk);
    stt_req = 1'b0;
    repeat (200) @(negedge clk);
    chk(stt_o == 1'b0 && evn == 0 && !scl_oe, "R13 mst low ignores start", evn, 0);
    mst = 1'b1;

    // R13: enable low aborts a running transfer
    xa = 1'b0; trx = 1'b1; sa = 10'h07F; cnt = 8'd4; stt_req = 1'b1; stp_req = 1'b1;
    @(negedge clk);
    stt_req = 1'b0; stp_req = 1'b0;
    repeat (150) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!scl_oe && !sda_oe && !stt_o, "R13 enable low releases", int'({scl_oe, sda_oe, stt_o}), 0);
    slv_lo = 1'b0; nack_idx = 99;
    stt_req = 1'b1;
    @(negedge clk);
    stt_req = 1'b0;
    repeat (100) @(negedge clk);
    chk(stt_o == 1'b0 && !scl_oe, "R13 enable low ignores start", int'(stt_o), 0);
    en = 1'b1;
    repeat (20) @(negedge clk);

    // R12: arbitration lost on first address bit
    run_xfer(0, 1, 10'h055, 1, 1, 99);
    a0 = ardy_cnt;
    al_en = 1;
    rd_mode = 0; ndata = 0; evn = 0; gidx = 0;
    xa = 1'b0; trx = 1'b1; sa = 10'h055; cnt = 8'd2; stt_req = 1'b1; stp_req = 1'b1;
    @(negedge clk);
    stt_req = 1'b0; stp_req = 1'b0;
    while (al_cnt == 0) @(negedge clk);
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R12 lines released after loss", int'({scl_oe, sda_oe}), 0);
    chk(ardy_cnt == a0, "R12 no ardy on loss", ardy_cnt - a0, 0);
    chk(al_cnt == 1, "R12 al pulse count", al_cnt, 1);
    al_en = 0; slv_lo = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy_o == 1'b0, "R11 busy cleared by stop", int'(busy_o), 0);
    chk(evlog[0][10:9] == 2'd1, "R3 only start before loss", int'(evlog[0][10:9]), 1);

    run_xfer(1, 0, 10'h3FF, 1, 1, 99);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule